// File: doc/BRIEF.md
# Serial Link Response Receiver

After a command frame has gone out on a two-wire serial link (a clock driven by the master and one bidirectional data line), this block takes over the link to collect the slave's reply. It drops its data-enable so that the data pin acts as an input. It then runs the link clock and samples the data line once per link clock period, on the high-to-low transition. The line is active low, so each sample is inverted to get the logical bit.

The receiver first looks for a start bit, and gives up after a bounded number of samples. After the start bit it shifts in a 4-bit response code. The code decides how many further bits follow. An acknowledge carries the number of data bits the requester asked for, followed by a 4-bit CRC. Any other code carries a fixed 7-bit trailer whose last four bits are the CRC. A running 4-bit CRC is folded over every received bit, starting with the start bit, and must end at zero.

The requester pulses `start_i` together with the expected data length. It gets back a one-cycle `done_o` together with a 3-bit status and the data field.

Top module: `lrx_resp_receiver`

## Requirements
- R1: While idle, `link_clk_o` is low, `link_den_o` is high and `busy_o` is low. From the cycle after an accepted `start_i` until the reply ends, `busy_o` is high and `link_den_o` is low.
- R2: While busy, `link_clk_o` toggles every system cycle, starting from low. `link_dat_i` is sampled at each edge where `link_clk_o` goes from high to low, and the logical bit is the inverse of the line level.
- R3: A start bit is a logical 1. The receiver searches for it for up to 512 samples (`WAIT_MAX`). A start bit found on the 512th sample is accepted.
- R4: If 512 samples pass without a start bit, the receiver stops the link clock after exactly 512 falling edges and reports status 4 (timeout) with `data_o` equal to 0.
- R5: The response code is the 4 bits after the start bit, most significant bit first. Code 0 is an acknowledge. It is followed by `len` data bits and then 4 CRC bits, and is reported as status 0.
- R6: Any nonzero code is followed by exactly 7 bits, whatever length was requested. Code 1 gives status 1 (busy), code 2 gives status 2 (error A), and code 3 or any code above 3 gives status 3 (error C).
- R7: The CRC register starts at 0. For each bit b it computes f = b xor c[3], then c = (c << 1) xor (f ? 4'b0111 : 4'b0000). The start bit, code, data and CRC bits are all folded in. A nonzero final value gives status 5 (CRC error), which overrides the code's status.
- R8: `data_o` holds the bits received after the code, with the last 4 removed and right-aligned, the earliest bit most significant. For a nonzero code this is the 3 trailer bits ahead of the CRC.
- R9: `done_o` is a one-cycle pulse in the cycle after the last sample, and `busy_o` falls in that same cycle. `status_o` and `data_o` hold their values until the next `done_o`.
- R10: `start_i` is ignored while busy. `data_len_i` is captured only when a start is accepted, and values above `DATA_W` are treated as `DATA_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin receiving a reply (ignored while busy) |
| data_len_i | input | $clog2(DATA_W+1) | Data bits expected on an acknowledge |
| link_clk_o | output | 1 | Serial link clock |
| link_den_o | output | 1 | Data-enable; low while the line is an input |
| link_dat_i | input | 1 | Serial data line, active low |
| busy_o | output | 1 | Reception in progress |
| done_o | output | 1 | One-cycle pulse marking a finished reply |
| status_o | output | 3 | 0 ack, 1 busy, 2 error A, 3 error C, 4 timeout, 5 CRC error |
| data_o | output | DATA_W | Received data field with the CRC removed |

## Verification
The assertions check the framing rules on every cycle. These are: data-enable is low and the link clock toggles whenever the block is busy, the clock rests low when idle, `done_o` lasts one cycle and coincides with the end of busy, results hold between completions, and a timeout always reports zero data. Only the bench scenarios can show that the right number of bits is taken for each response code, that the CRC residue test and its priority over the code are correct, that the 512-sample boundary falls on the right side, and that a second start during a reception changes nothing. The bench counts falling link clock edges to check these.

// File: rtl/lrx_pkg.sv
package lrx_pkg;

    typedef enum logic [2:0] {
        RS_ACK     = 3'd0,
        RS_BUSY    = 3'd1,
        RS_ERR_A   = 3'd2,
        RS_ERR_C   = 3'd3,
        RS_TIMEOUT = 3'd4,
        RS_CRC_ERR = 3'd5
    } lrx_status_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HUNT,
        PH_CODE,
        PH_BODY
    } lrx_phase_e;

    localparam int CODE_W = 4;
    localparam int CRC_W  = 4;

    function automatic lrx_status_e code_to_status(input logic [CODE_W-1:0] code);
        case (code)
            4'd0:    return RS_ACK;
            4'd1:    return RS_BUSY;
            4'd2:    return RS_ERR_A;
            default: return RS_ERR_C;
        endcase
    endfunction

endpackage

// File: rtl/lrx_crc_step.sv
// One bit of the 4-bit link CRC: shift left, feed back the polynomial when
// the incoming bit differs from the top bit.
module lrx_crc_step #(
    parameter int          W    = 4,
    parameter logic [W-1:0] POLY = 4'b0111
) (
    input  logic [W-1:0] crc_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic fb;

    always_comb begin
        fb    = bit_i ^ crc_i[W-1];
        crc_o = {crc_i[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
endmodule

// File: rtl/lrx_clkgen.sv
// Link clock: toggles each cycle while running, rests low otherwise.
// fall_o marks the edge on which the link clock goes high to low.
module lrx_clkgen (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic link_clk_o,
    output logic fall_o
);
    logic lclk_d, lclk_q;

    always_comb begin
        lclk_d = run_i ? ~lclk_q : 1'b0;
        fall_o = run_i & lclk_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lclk_q <= 1'b0;
        else        lclk_q <= lclk_d;
    end

    assign link_clk_o = lclk_q;
endmodule

// File: rtl/lrx_resp_receiver.sv
module lrx_resp_receiver
    import lrx_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int WAIT_MAX = 512,
    parameter int TRAILER  = 7,
    localparam int LEN_W   = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  data_len_i,
    output logic              link_clk_o,
    output logic              link_den_o,
    input  logic              link_dat_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [2:0]        status_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int SR_W   = DATA_W + CRC_W;
    localparam int CNT_W  = $clog2(SR_W + 1);
    localparam int WAIT_W = $clog2(WAIT_MAX);

    typedef struct packed {
        lrx_phase_e        ph;
        logic [WAIT_W-1:0] wait_cnt;
        logic [CNT_W-1:0]  bit_cnt;
        logic [CNT_W-1:0]  body_len;
        logic [LEN_W-1:0]  len;
        logic [CODE_W-1:0] code;
        logic [CRC_W-1:0]  crc;
        logic [SR_W-1:0]   sr;
        logic              done;
        lrx_status_e       status;
        logic [DATA_W-1:0] data;
    } rx_regs_t;

    rx_regs_t q, d;

    logic             running;
    logic             fall;
    logic             rx_bit;
    logic [CRC_W-1:0] crc_nx;
    logic [CODE_W-1:0] code_nx;
    logic [SR_W-1:0]  sr_nx;

    assign running = (q.ph != PH_IDLE);
    assign rx_bit  = ~link_dat_i;

    lrx_clkgen u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (running),
        .link_clk_o (link_clk_o),
        .fall_o     (fall)
    );

    lrx_crc_step #(.W(CRC_W), .POLY(4'b0111)) u_crc (
        .crc_i (q.crc),
        .bit_i (rx_bit),
        .crc_o (crc_nx)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        code_nx = {q.code[CODE_W-2:0], rx_bit};
        sr_nx   = {q.sr[SR_W-2:0], rx_bit};

        case (q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    d.ph       = PH_HUNT;
                    d.wait_cnt = '0;
                    d.bit_cnt  = '0;
                    d.code     = '0;
                    d.crc      = '0;
                    d.sr       = '0;
                    d.len      = (data_len_i > LEN_W'(DATA_W)) ? LEN_W'(DATA_W) : data_len_i;
                end
            end
            PH_HUNT: begin
                if (fall) begin
                    if (rx_bit) begin
                        d.ph  = PH_CODE;
                        d.crc = crc_nx;
                    end else if (q.wait_cnt == WAIT_W'(WAIT_MAX - 1)) begin
                        d.ph     = PH_IDLE;
                        d.done   = 1'b1;
                        d.status = RS_TIMEOUT;
                        d.data   = '0;
                    end else begin
                        d.wait_cnt = q.wait_cnt + WAIT_W'(1);
                    end
                end
            end
            PH_CODE: begin
                if (fall) begin
                    d.code = code_nx;
                    d.crc  = crc_nx;
                    if (q.bit_cnt == CNT_W'(CODE_W - 1)) begin
                        d.ph       = PH_BODY;
                        d.bit_cnt  = '0;
                        d.body_len = (code_nx == '0) ? CNT_W'(q.len) + CNT_W'(CRC_W)
                                                     : CNT_W'(TRAILER);
                    end else begin
                        d.bit_cnt = q.bit_cnt + CNT_W'(1);
                    end
                end
            end
            PH_BODY: begin
                if (fall) begin
                    d.sr  = sr_nx;
                    d.crc = crc_nx;
                    if (q.bit_cnt == q.body_len - CNT_W'(1)) begin
                        d.ph     = PH_IDLE;
                        d.done   = 1'b1;
                        d.data   = sr_nx[SR_W-1:CRC_W];
                        d.status = (crc_nx != '0) ? RS_CRC_ERR : code_to_status(q.code);
                    end else begin
                        d.bit_cnt = q.bit_cnt + CNT_W'(1);
                    end
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o     = running;
    assign link_den_o = ~running;
    assign done_o     = q.done;
    assign status_o   = q.status;
    assign data_o     = q.data;
endmodule

// File: rtl/lrx_resp_receiver_chk.sv
module lrx_resp_receiver_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              link_clk_o,
    input logic              link_den_o,
    input logic [2:0]        status_o,
    input logic [DATA_W-1:0] data_o
);
    a_r1_den_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !link_den_o);

    a_r1_clk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !link_clk_o);

    a_r2_clk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (link_clk_o != $past(link_clk_o)));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_busy_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(status_o) && $stable(data_o)));

    a_r4_timeout_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o == 3'd4) |-> (data_o == '0));

    a_r6_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (status_o <= 3'd5));
endmodule

bind lrx_resp_receiver lrx_resp_receiver_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .link_clk_o (link_clk_o),
    .link_den_o (link_den_o),
    .status_o   (status_o),
    .data_o     (data_o)
);

// File: tb/sim_lrx_resp_receiver.sv
module sim_lrx_resp_receiver;
    localparam int DATA_W    = 32;
    localparam int LEN_W     = $clog2(DATA_W + 1);
    localparam int FRAME_MAX = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [LEN_W-1:0]  data_len_i = '0;
    logic              link_clk_o;
    logic              link_den_o;
    logic              link_dat_i = 1'b1;
    logic              busy_o;
    logic              done_o;
    logic [2:0]        status_o;
    logic [DATA_W-1:0] data_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int sidx   = 0;
    int falls  = 0;
    logic frame [0:FRAME_MAX-1];

    lrx_resp_receiver #(.DATA_W(DATA_W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .data_len_i (data_len_i),
        .link_clk_o (link_clk_o),
        .link_den_o (link_den_o),
        .link_dat_i (link_dat_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .status_o   (status_o),
        .data_o     (data_o)
    );

    initial forever #4 clk = ~clk;

    // slave model: advance to the next bit after each falling link clock edge
    initial forever begin
        @(negedge link_clk_o);
        #1;
        falls++;
        if (sidx < FRAME_MAX - 1) sidx++;
        link_dat_i = ~frame[sidx];
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog: run did not end, actual cycles %0d expected < 150000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_crc(input logic [3:0] c, input logic b);
        logic f;
        f = b ^ c[3];
        return {c[2:0], 1'b0} ^ (f ? 4'b0111 : 4'b0000);
    endfunction

    // build a logical frame: pre idle zeros, start, code, body, crc
    task automatic build(input int pre, input logic [3:0] code, input int nbits,
                         input logic [31:0] payload, input bit corrupt);
        logic [3:0] c;
        int p;
        for (int i = 0; i < FRAME_MAX; i++) frame[i] = 1'b0;
        p = pre;
        frame[p] = 1'b1;
        c = ref_crc(4'h0, 1'b1);
        p++;
        for (int i = 3; i >= 0; i--) begin
            frame[p] = code[i];
            c = ref_crc(c, code[i]);
            p++;
        end
        for (int i = nbits - 1; i >= 0; i--) begin
            frame[p] = payload[i];
            c = ref_crc(c, payload[i]);
            p++;
        end
        for (int i = 3; i >= 0; i--) begin
            frame[p] = c[i];
            p++;
        end
        if (corrupt) frame[p-1] = ~frame[p-1];
    endtask

    // run one reply and check status, data and falling-edge count
    task automatic run(input string req, input int pre, input logic [3:0] code,
                       input int nbits, input logic [31:0] payload, input int req_len,
                       input bit corrupt, input bit poke, input int exp_st,
                       input logic [31:0] exp_data, input int exp_falls);
        bit seen;
        build(pre, code, nbits, payload, corrupt);
        sidx = 0;
        link_dat_i = ~frame[0];
        falls = 0;
        @(negedge clk);
        start_i = 1'b1;
        data_len_i = LEN_W'(req_len);
        @(negedge clk);
        start_i = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 4000 && !seen; i++) begin
            @(negedge clk);
            if (i == 2)
                chk(busy_o && !link_den_o, "R1", "busy/den during reply",
                    {busy_o, link_den_o}, 2'b10);
            if (poke && i == 20) begin start_i = 1'b1; data_len_i = '0; end
            if (poke && i == 21) start_i = 1'b0;
            if (done_o) seen = 1'b1;
        end
        chk(seen, req, "done seen", seen, 1);
        if (seen) begin
            chk(status_o == 3'(exp_st), req, "status", status_o, exp_st);
            if (exp_st != 5)
                chk(data_o == exp_data, req, "data", data_o, exp_data);
            chk(falls == exp_falls, req, "falling edges", falls, exp_falls);
            chk(!busy_o && link_den_o, "R9", "busy low at done", {busy_o, link_den_o}, 2'b01);
            @(negedge clk);
            chk(!done_o && !link_clk_o, "R9", "done one cycle, clock parked",
                {done_o, link_clk_o}, 0);
        end
    endtask

    task automatic t_reset();
        chk(!busy_o && link_den_o && !link_clk_o && !done_o, "R1", "reset idle outputs",
            {busy_o, link_den_o, link_clk_o, done_o}, 4'b0100);
    endtask

    task automatic t_ack_read();   // R5 R8 R2
        run("R5", 5, 4'd0, 32, 32'hDEADBEEF, 32, 0, 0, 0, 32'hDEADBEEF, 5 + 5 + 36);
    endtask

    task automatic t_ack_write();  // R5 zero-length data
        run("R5", 0, 4'd0, 0, 32'h0, 0, 0, 0, 0, 32'h0, 0 + 5 + 4);
    endtask

    task automatic t_ack_short();  // R8 right-aligned short field
        run("R8", 2, 4'd0, 12, 32'h00000ABC, 12, 0, 0, 0, 32'h00000ABC, 2 + 5 + 16);
    endtask

    task automatic t_busy();       // R6 fixed trailer regardless of request
        run("R6", 3, 4'd1, 3, 32'h5, 32, 0, 0, 1, 32'h5, 3 + 5 + 7);
    endtask

    task automatic t_err_a();
        run("R6", 1, 4'd2, 3, 32'h2, 0, 0, 0, 2, 32'h2, 1 + 5 + 7);
    endtask

    task automatic t_err_c();
        run("R6", 4, 4'd3, 3, 32'h7, 8, 0, 0, 3, 32'h7, 4 + 5 + 7);
    endtask

    task automatic t_code_high();  // R6 codes above 3 map to error C
        run("R6", 0, 4'd9, 3, 32'h1, 16, 0, 0, 3, 32'h1, 0 + 5 + 7);
    endtask

    task automatic t_crc_bad();    // R7 nonzero residue overrides the code
        run("R7", 2, 4'd0, 16, 32'h0000C3A5, 16, 1, 0, 5, 32'h0, 2 + 5 + 20);
        run("R7", 2, 4'd1, 3, 32'h3, 16, 1, 0, 5, 32'h0, 2 + 5 + 7);
    endtask

    task automatic t_timeout();    // R4
        run("R4", 600, 4'd0, 8, 32'hFF, 8, 0, 0, 4, 32'h0, 512);
    endtask

    task automatic t_late_start(); // R3 start on the 512th sample
        run("R3", 511, 4'd0, 8, 32'h5A, 8, 0, 0, 0, 32'h5A, 511 + 5 + 12);
    endtask

    task automatic t_clamp();      // R10 length above DATA_W clamps
        run("R10", 1, 4'd0, 32, 32'h12345678, 40, 0, 0, 0, 32'h12345678, 1 + 5 + 36);
    endtask

    task automatic t_poke();       // R10 start while busy ignored
        run("R10", 6, 4'd0, 32, 32'hCAFE0F0F, 32, 0, 1, 0, 32'hCAFE0F0F, 6 + 5 + 36);
    endtask

    initial begin
        for (int i = 0; i < FRAME_MAX; i++) frame[i] = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ack_read();
        t_ack_write();
        t_ack_short();
        t_busy();
        t_err_a();
        t_err_c();
        t_code_high();
        t_crc_bad();
        t_timeout();
        t_late_start();
        t_clamp();
        t_poke();
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule